// File: doc/BRIEF.md
# Contour Moment Accumulator

This block collects the boundary pixels of one contour as a stream of unsigned (x, y) coordinates. While the stream runs it keeps only running totals: the number of pixels, the sums of x and y, and the sums of x·x, x·y and y·y. Each accepted pixel costs only additions and multiplications. No mean is known yet, so nothing is subtracted per pixel.

The frame ends with a beat marked last. The block then stops taking input and runs a fixed finishing sequence. One shared sequential divider first produces the two mean positions. It then produces the three mean second-order products. The squared means are formed once from the stored mean values, and each central moment is the mean of the product minus the product of the means. The results come out together with a one-cycle valid pulse. The totals are cleared for the next contour. A downstream ellipse stage would use the count, the means and the three moments.

All results are fixed point with 8 fractional bits. A frame that carries no pixel gives zero results and is flagged as empty.

Top module: `contour_moment_acc`

## Requirements
- R1: After reset, in_ready is 1 and res_valid is 0.
- R2: A beat is accepted on a clock edge where in_valid and in_ready are both 1. An accepted beat with in_nopix = 0 adds one pixel (in_x, in_y). res_count reports the number of such pixels in the frame.
- R3: With x up to 9 bits and y up to 8 bits, the totals do not overflow for frames of up to 92160 pixels.
- R4: res_mean_x = floor(256·Σx / n) and res_mean_y = floor(256·Σy / n), both unsigned with 8 fractional bits.
- R5: res_mxx = floor(256·Σx² / n) − floor(res_mean_x² / 256). res_myy is formed the same way from y. Both are unsigned with 8 fractional bits.
- R6: res_mxy = floor(256·Σxy / n) − floor(res_mean_x·res_mean_y / 256), in two's complement with 8 fractional bits.
- R7: An accepted beat with in_nopix = 1 adds nothing to the totals. If it also carries in_last = 1, it still closes the frame.
- R8: After the edge that accepts a last beat, in_ready stays 0 until the cycle in which res_valid is 1. Beats offered in that window are not taken.
- R9: res_valid is high for exactly one cycle. The result outputs hold their values until the next result. The following frame starts from cleared totals.
- R10: A frame with no pixels gives res_empty = 1 and all other result outputs 0. A frame with pixels gives res_empty = 0.
- R11: res_valid rises 5·W + 8 clock edges after the edge that accepts the last beat, where W = 2·9 + 17 + 8 = 43 is the scaled-dividend width. For an empty frame it rises 2 edges after that edge. The latency does not depend on n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Coordinate beat offered |
| in_ready | output | 1 | Block can take a beat |
| in_x | input | 9 | Pixel column, unsigned |
| in_y | input | 8 | Pixel row, unsigned |
| in_last | input | 1 | Beat closes the contour |
| in_nopix | input | 1 | Beat carries no pixel |
| res_valid | output | 1 | One-cycle result strobe |
| res_empty | output | 1 | Contour had no pixels |
| res_count | output | 17 | Pixel count n |
| res_mean_x | output | 17 | Mean x, 8 fractional bits |
| res_mean_y | output | 16 | Mean y, 8 fractional bits |
| res_mxx | output | 26 | Central moment in x, 8 fractional bits |
| res_mxy | output | 26 | Signed cross moment, 8 fractional bits |
| res_myy | output | 24 | Central moment in y, 8 fractional bits |

## Verification
The assertions check several properties on every cycle. Each running total stays within the bound that its pixel count permits. Input is refused right after a last beat. The valid strobe is a single cycle, and the totals are already cleared when it fires. An empty result is all zeros, a single-pixel contour has zero spread, and the divider remainder stays below the divisor. The exact arithmetic of the means and moments, the rounding of the subtraction stage, and the sign of the cross moment can only be shown by the bench. The same holds for the fixed latency, the handling of no-pixel beats and the full-size frame. The bench compares each frame against sums that it computes itself, over ordered shapes, pseudo-random contours and corner positions.

// File: rtl/cma_pkg.sv
// Shared definitions for the contour moment accumulator.
// Assumes: nothing beyond the parameters of the top module.
package cma_pkg;
    typedef enum logic [2:0] {
        ST_ACC = 3'd0,   // taking coordinates
        ST_CHK = 3'd1,   // frame closed, test for empty
        ST_DIV = 3'd2,   // five sequential divisions
        ST_SQR = 3'd3,   // squares of the means
        ST_OUT = 3'd4    // subtract and publish
    } cma_state_t;

    // order in which the shared divider works through the totals
    localparam logic [2:0] SEL_X  = 3'd0;
    localparam logic [2:0] SEL_Y  = 3'd1;
    localparam logic [2:0] SEL_XX = 3'd2;
    localparam logic [2:0] SEL_XY = 3'd3;
    localparam logic [2:0] SEL_YY = 3'd4;
endpackage

// File: rtl/cma_accum.sv
// Running totals for one contour: pixel count and the sums of x, y,
// x*x, x*y and y*y. One pixel per cycle, additions and products only.
// Assumes: x width >= y width; at most MAXN pixels between clears.
module cma_accum #(
    parameter int XW   = 9,
    parameter int YW   = 8,
    parameter int MAXN = 92160,
    parameter int CNTW = 17,
    parameter int SW   = 2 * XW + CNTW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            add,
    input  logic [XW-1:0]   x,
    input  logic [YW-1:0]   y,
    output logic [CNTW-1:0] cnt,
    output logic [SW-1:0]   sx,
    output logic [SW-1:0]   sy,
    output logic [SW-1:0]   sxx,
    output logic [SW-1:0]   sxy,
    output logic [SW-1:0]   syy
);
    localparam int XMAX = (1 << XW) - 1;
    localparam int YMAX = (1 << YW) - 1;

    logic [SW-1:0] xe, ye;

    // widen coordinates before forming products
    always_comb begin
        xe = SW'(x);
        ye = SW'(y);
    end

    // accumulate one pixel or clear for the next contour
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
            sx  <= '0;
            sy  <= '0;
            sxx <= '0;
            sxy <= '0;
            syy <= '0;
        end else if (add) begin
            cnt <= cnt + CNTW'(1);
            sx  <= sx + xe;
            sy  <= sy + ye;
            sxx <= sxx + xe * xe;
            sxy <= sxy + xe * ye;
            syy <= syy + ye * ye;
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        add |-> cnt < CNTW'(MAXN));
    assert_sum_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sx <= SW'(cnt) * SW'(XMAX)) && (sxx <= SW'(cnt) * SW'(XMAX * XMAX))
        && (syy <= SW'(cnt) * SW'(YMAX * YMAX)));
endmodule

// File: rtl/cma_divider.sv
// Bit-serial restoring divider: one quotient bit per cycle, NUMW cycles.
// A start while idle loads operands; done pulses one cycle after the last
// step and quot holds until the next start. Assumes den is non-zero.
module cma_divider #(
    parameter int NUMW = 43,
    parameter int DENW = 17,
    parameter int QW   = 26
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NUMW-1:0] num,
    input  logic [DENW-1:0] den,
    output logic            busy,
    output logic            done,
    output logic [QW-1:0]   quot
);
    localparam int CW = $clog2(NUMW + 1);

    logic [NUMW-1:0] q;
    logic [DENW-1:0] rem, d;
    logic [CW-1:0]   cnt;
    logic [DENW:0]   trial;
    logic            fits;

    // partial remainder with the next dividend bit brought down
    always_comb begin
        trial = {rem, q[NUMW-1]};
        fits  = trial >= {1'b0, d};
    end

    // load operands, then shift-subtract one bit per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            rem  <= '0;
            d    <= '0;
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                q    <= num;
                rem  <= '0;
                d    <= den;
                cnt  <= CW'(NUMW);
                busy <= 1'b1;
            end else if (busy) begin
                if (fits) rem <= DENW'(trial - {1'b0, d});
                else      rem <= trial[DENW-1:0];
                q   <= {q[NUMW-2:0], fits};
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = q[QW-1:0];

    assert_done_follows_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    assert_rem_below_divisor_R4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> rem < d);
endmodule

// File: rtl/contour_moment_acc.sv
// Contour moment accumulator. Takes a framed coordinate stream, keeps sums,
// and after the last beat derives count, means and central moments with
// one shared divider (means first, reused for the squared-mean terms).
// Assumes: frames of at most MAXN pixels; x width >= y width.
module contour_moment_acc #(
    parameter int XW   = 9,
    parameter int YW   = 8,
    parameter int FRAC = 8,
    parameter int MAXN = 92160
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    output logic                              in_ready,
    input  logic [XW-1:0]                     in_x,
    input  logic [YW-1:0]                     in_y,
    input  logic                              in_last,
    input  logic                              in_nopix,
    output logic                              res_valid,
    output logic                              res_empty,
    output logic [$clog2(MAXN+1)-1:0]         res_count,
    output logic [XW+FRAC-1:0]                res_mean_x,
    output logic [YW+FRAC-1:0]                res_mean_y,
    output logic [2*XW+FRAC-1:0]              res_mxx,
    output logic signed [XW+YW+FRAC:0]        res_mxy,
    output logic [2*YW+FRAC-1:0]              res_myy
);
    import cma_pkg::*;

    localparam int CNTW = $clog2(MAXN + 1);
    localparam int SW   = 2 * XW + CNTW;
    localparam int NUMW = SW + FRAC;
    localparam int MXW  = XW + FRAC;
    localparam int MYW  = YW + FRAC;
    localparam int MXXW = 2 * XW + FRAC;
    localparam int MYYW = 2 * YW + FRAC;
    localparam int MXYU = XW + YW + FRAC;
    localparam int MXYW = MXYU + 1;
    localparam int XMAX = (1 << XW) - 1;
    localparam int YMAX = (1 << YW) - 1;

    cma_state_t      state;
    logic [2:0]      sel, nsel;
    logic            fire, acc_add, acc_clr;
    logic [CNTW-1:0] acc_cnt;
    logic [SW-1:0]   acc_sx, acc_sy, acc_sxx, acc_sxy, acc_syy;
    logic            div_start, div_busy, div_done;
    logic [NUMW-1:0] div_num;
    logic [MXXW-1:0] div_quot;

    logic [MXW-1:0]  q_mx;
    logic [MYW-1:0]  q_my;
    logic [MXXW-1:0] q_xx, p_xx;
    logic [MXYU-1:0] q_xy, p_xy;
    logic [MYYW-1:0] q_yy, p_yy;
    logic [2*MXW-1:0]   mx_sq;
    logic [MXW+MYW-1:0] mx_e, my_e;
    logic [2*MYW-1:0]   my_sq;

    // handshake and accumulator control
    always_comb begin
        in_ready = (state == ST_ACC);
        fire     = in_valid && in_ready;
        acc_add  = fire && !in_nopix;
        acc_clr  = (state == ST_OUT);
    end

    cma_accum #(.XW(XW), .YW(YW), .MAXN(MAXN), .CNTW(CNTW), .SW(SW)) accum_i (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .add(acc_add),
        .x(in_x), .y(in_y), .cnt(acc_cnt),
        .sx(acc_sx), .sy(acc_sy), .sxx(acc_sxx), .sxy(acc_sxy), .syy(acc_syy)
    );

    // pick the next total to divide and decide when to launch it
    always_comb begin
        nsel      = (state == ST_CHK) ? SEL_X : 3'(sel + 3'd1);
        div_start = ((state == ST_CHK) && (acc_cnt != '0)) ||
                    ((state == ST_DIV) && div_done && (sel != SEL_YY));
        case (nsel)
            SEL_X:   div_num = NUMW'(acc_sx)  << FRAC;
            SEL_Y:   div_num = NUMW'(acc_sy)  << FRAC;
            SEL_XX:  div_num = NUMW'(acc_sxx) << FRAC;
            SEL_XY:  div_num = NUMW'(acc_sxy) << FRAC;
            default: div_num = NUMW'(acc_syy) << FRAC;
        endcase
    end

    cma_divider #(.NUMW(NUMW), .DENW(CNTW), .QW(MXXW)) div_i (
        .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num),
        .den(acc_cnt), .busy(div_busy), .done(div_done), .quot(div_quot)
    );

    // widened mean operands for the squared-mean products
    always_comb begin
        mx_sq = {{MXW{1'b0}}, q_mx};
        my_sq = {{MYW{1'b0}}, q_my};
        mx_e  = (MXW+MYW)'(q_mx);
        my_e  = (MXW+MYW)'(q_my);
    end

    // finishing sequence: divisions, squared means, subtraction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_ACC;
            sel   <= SEL_X;
            q_mx  <= '0;
            q_my  <= '0;
            q_xx  <= '0;
            q_xy  <= '0;
            q_yy  <= '0;
            p_xx  <= '0;
            p_xy  <= '0;
            p_yy  <= '0;
        end else begin
            case (state)
                ST_ACC: if (fire && in_last) state <= ST_CHK;
                ST_CHK: begin
                    sel   <= SEL_X;
                    state <= (acc_cnt == '0) ? ST_OUT : ST_DIV;
                end
                ST_DIV: if (div_done) begin
                    case (sel)
                        SEL_X:   q_mx <= div_quot[MXW-1:0];
                        SEL_Y:   q_my <= div_quot[MYW-1:0];
                        SEL_XX:  q_xx <= div_quot;
                        SEL_XY:  q_xy <= div_quot[MXYU-1:0];
                        default: q_yy <= div_quot[MYYW-1:0];
                    endcase
                    sel <= nsel;
                    if (sel == SEL_YY) state <= ST_SQR;
                end
                ST_SQR: begin
                    p_xx  <= MXXW'((mx_sq * mx_sq) >> FRAC);
                    p_xy  <= MXYU'((mx_e * my_e) >> FRAC);
                    p_yy  <= MYYW'((my_sq * my_sq) >> FRAC);
                    state <= ST_OUT;
                end
                default: state <= ST_ACC;
            endcase
        end
    end

    // publish results with a single-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_empty  <= 1'b0;
            res_count  <= '0;
            res_mean_x <= '0;
            res_mean_y <= '0;
            res_mxx    <= '0;
            res_mxy    <= '0;
            res_myy    <= '0;
        end else begin
            res_valid <= (state == ST_OUT);
            if (state == ST_OUT) begin
                res_count <= acc_cnt;
                res_empty <= (acc_cnt == '0);
                if (acc_cnt == '0) begin
                    res_mean_x <= '0;
                    res_mean_y <= '0;
                    res_mxx    <= '0;
                    res_mxy    <= '0;
                    res_myy    <= '0;
                end else begin
                    res_mean_x <= q_mx;
                    res_mean_y <= q_my;
                    res_mxx    <= q_xx - p_xx;
                    res_mxy    <= $signed({1'b0, q_xy}) - $signed({1'b0, p_xy});
                    res_myy    <= q_yy - p_yy;
                end
            end
        end
    end

    assert_ready_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_last) |=> !in_ready);
    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    assert_cleared_on_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (acc_cnt == '0) && in_ready);
    assert_empty_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_empty) |-> (res_count == '0) && (res_mean_x == '0) &&
        (res_mean_y == '0) && (res_mxx == '0) && (res_mxy == '0) && (res_myy == '0));
    assert_mean_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_mean_x <= MXW'(XMAX << FRAC)) && (res_mean_y <= MYW'(YMAX << FRAC)));
    assert_single_pixel_flat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_count == CNTW'(1)) |-> (res_mxx == '0) && (res_myy == '0) && (res_mxy == '0));
endmodule

// File: tb/contour_moment_acc_tb_top.sv
// Bench: streams contours, models the sums arithmetically, compares results.
module contour_moment_acc_tb_top;
    localparam int  CLK_PERIOD = 10;
    localparam int  NUMW_B     = 2 * 9 + 17 + 8;
    localparam int  LAT_FULL   = 5 * NUMW_B + 8;
    localparam int  LAT_EMPTY  = 2;
    localparam int  WATCHDOG   = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, in_nopix = 1'b0;
    logic [8:0] in_x = '0;
    logic [7:0] in_y = '0;
    logic in_ready, res_valid, res_empty;
    logic [16:0] res_count, res_mean_x;
    logic [15:0] res_mean_y;
    logic [25:0] res_mxx;
    logic signed [25:0] res_mxy;
    logic [23:0] res_myy;

    int vectors = 0, miscompares = 0, cycles = 0;
    longint e_n = 0, e_sx = 0, e_sy = 0, e_sxx = 0, e_sxy = 0, e_syy = 0;
    int unsigned seed = 32'h1234_5678;

    always #(CLK_PERIOD / 2) clk = ~clk;

    contour_moment_acc dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_x(in_x), .in_y(in_y), .in_last(in_last), .in_nopix(in_nopix),
        .res_valid(res_valid), .res_empty(res_empty), .res_count(res_count),
        .res_mean_x(res_mean_x), .res_mean_y(res_mean_y), .res_mxx(res_mxx),
        .res_mxy(res_mxy), .res_myy(res_myy)
    );

    task automatic summary_and_end();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                miscompares++;
                $display("FAIL watchdog: act=%0d cycles exp<=%0d", cycles, WATCHDOG);
                summary_and_end();
            end
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed >> 8;
    endfunction

    // offer one beat and wait until it is taken
    task automatic send(input int x, input int y, input bit last, input bit nopix);
        @(negedge clk);
        in_valid = 1'b1;
        in_x = 9'(x);
        in_y = 8'(y);
        in_last = last;
        in_nopix = nopix;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        if (!nopix) begin
            e_n++;
            e_sx += x;
            e_sy += y;
            e_sxx += longint'(x) * x;
            e_sxy += longint'(x) * y;
            e_syy += longint'(y) * y;
        end
    endtask

    // after the last beat: optional junk offers, wait, compare, check hold
    task automatic finish_frame(input bit junk, input string tag);
        int lat = 0;
        longint mx, my, mxx, mxy, myy;
        logic [25:0] h_mxx;
        logic [16:0] h_mx;
        forever begin
            @(negedge clk);
            lat++;
            if (lat == 1) begin
                in_valid = junk;
                in_last = 1'b0;
                in_nopix = 1'b0;
                in_x = 9'd77;
                in_y = 8'd201;
            end
            if (lat == 100) in_valid = 1'b0;
            if (res_valid) break;
            if (in_ready) begin
                chk({"R8 ready low while finishing ", tag}, 1, 0);
                break;
            end
            if (lat > 2000) break;
        end
        in_valid = 1'b0;
        if (e_n == 0) begin
            mx = 0; my = 0; mxx = 0; mxy = 0; myy = 0;
        end else begin
            mx  = (e_sx * 256) / e_n;
            my  = (e_sy * 256) / e_n;
            mxx = (e_sxx * 256) / e_n - (mx * mx) / 256;
            mxy = (e_sxy * 256) / e_n - (mx * my) / 256;
            myy = (e_syy * 256) / e_n - (my * my) / 256;
        end
        chk({"R11 latency ", tag}, lat - 1, (e_n == 0) ? LAT_EMPTY : LAT_FULL);
        chk({"R2 count ", tag}, res_count, e_n);
        chk({"R10 empty flag ", tag}, res_empty, (e_n == 0) ? 1 : 0);
        chk({"R4 mean x ", tag}, res_mean_x, mx);
        chk({"R4 mean y ", tag}, res_mean_y, my);
        chk({"R5 mxx ", tag}, res_mxx, mxx);
        chk({"R6 mxy ", tag}, longint'(res_mxy), mxy);
        chk({"R5 myy ", tag}, res_myy, myy);
        h_mxx = res_mxx;
        h_mx = res_mean_x;
        @(negedge clk);
        chk({"R9 pulse one cycle ", tag}, res_valid, 0);
        chk({"R9 result held ", tag}, (res_mxx == h_mxx && res_mean_x == h_mx) ? 1 : 0, 1);
        e_n = 0; e_sx = 0; e_sy = 0; e_sxx = 0; e_sxy = 0; e_syy = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 ready after reset", in_ready, 1);
        chk("R1 no result after reset", res_valid, 0);

        // single corner pixels
        send(0, 0, 1'b1, 1'b0);
        finish_frame(1'b0, "origin");
        send(511, 255, 1'b1, 1'b0);
        finish_frame(1'b1, "far corner, junk offered R8");

        // empty frame closed by a no-pixel last beat (R7, R10)
        send(300, 100, 1'b1, 1'b1);
        finish_frame(1'b0, "empty R10");

        // no-pixel beats with junk coordinates inside a frame (R7)
        send(10, 20, 1'b0, 1'b0);
        send(500, 250, 1'b0, 1'b1);
        send(30, 5, 1'b0, 1'b0);
        send(499, 3, 1'b1, 1'b1);
        finish_frame(1'b0, "nopix ignored R7");

        // diagonal line (positive cross moment) and anti-diagonal (negative)
        for (int i = 0; i < 20; i++) send(i * 10, i * 5, i == 19, 1'b0);
        finish_frame(1'b0, "diagonal R6");
        for (int i = 0; i < 20; i++) send(i * 10, 200 - i * 7, i == 19, 1'b0);
        finish_frame(1'b0, "anti-diagonal R6");

        // square outline
        for (int i = 0; i < 16; i++) send(100 + i, 50, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) send(115, 50 + i, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) send(115 - i, 65, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) send(100, 65 - i, i == 15, 1'b0);
        finish_frame(1'b0, "square outline");

        // pseudo-random contours, some with no-pixel beats
        for (int f = 0; f < 50; f++) begin
            int len = int'(rnd() % 40) + 1;
            for (int i = 0; i < len; i++)
                send(int'(rnd() % 512), int'(rnd() % 256), i == len - 1, (rnd() % 8) == 0);
            finish_frame(f % 3 == 0, "random");
        end

        // full-size frame at the maximum coordinate (R3)
        for (int i = 0; i < 92160; i++) send(511, 255, i == 92159, 1'b0);
        finish_frame(1'b0, "full size R3");

        // totals cleared: a small frame right after the large one (R9)
        send(4, 8, 1'b0, 1'b0);
        send(6, 2, 1'b1, 1'b0);
        finish_frame(1'b0, "after large R9");

        summary_and_end();
    end
endmodule